// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block raises doorbell interrupts between the two sides of a shared two-port memory. Each side owns one mailbox word at the top of the address space: side A owns the address one below all-ones, side B owns the all-ones address. When one side writes into the other side's mailbox, the owner's interrupt line goes low. The owner clears it again by reading its own mailbox. The mailbox data lives in the ordinary memory array. This block handles only the two flags.

The controller watches the control inputs of both sides on a single clock: enable, write strobe, output enable, address and busy, all active low except the address. The flags are registered, so a qualifying access becomes visible on the interrupt pin one clock after the access is sampled. Each side's busy input suppresses that side's own accesses. When the interrupt function is switched off by parameter, both flags stay deasserted and the two mailbox words act as plain memory.

Top module: `mbx_irq_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, both `a_irq_n` and `b_irq_n` are high (deasserted).
- R2: A sampled cycle with `b_en_n`=0, `b_wr_n`=0, `b_busy_n`=1 and `b_addr` equal to all-ones minus one drives `a_irq_n` low from the next clock edge.
- R3: A sampled cycle with `a_en_n`=0, `a_wr_n`=0, `a_busy_n`=1 and `a_addr` equal to all-ones drives `b_irq_n` low from the next clock edge.
- R4: A sampled cycle with `a_en_n`=0, `a_oe_n`=0, `a_busy_n`=1 and `a_addr` equal to all-ones minus one returns `a_irq_n` high at the next edge, whatever the value of `a_wr_n`.
- R5: A sampled cycle with `b_en_n`=0, `b_oe_n`=0, `b_busy_n`=1 and `b_addr` equal to all-ones returns `b_irq_n` high at the next edge.
- R6: An access made while the acting side's busy input is low neither sets nor clears any flag.
- R7: When a set and a clear of the same flag are sampled in the same cycle, the flag is low after the edge.
- R8: These accesses leave both flags unchanged: writes to any other address, a write by a side to its own mailbox, reads of a mailbox by the side that does not own it, and accesses with enable high.
- R9: With no qualifying set or clear, each flag holds its value from cycle to cycle.
- R10: With parameter `IRQ_EN`=0, both flags stay high whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_en_n | input | 1 | Side A access enable, active low |
| a_wr_n | input | 1 | Side A write strobe, low = write |
| a_oe_n | input | 1 | Side A output enable, active low |
| a_addr | input | ADDR_W | Side A address |
| a_busy_n | input | 1 | Side A busy, low suppresses side A accesses |
| b_en_n | input | 1 | Side B access enable, active low |
| b_wr_n | input | 1 | Side B write strobe, low = write |
| b_oe_n | input | 1 | Side B output enable, active low |
| b_addr | input | ADDR_W | Side B address |
| b_busy_n | input | 1 | Side B busy, low suppresses side B accesses |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
The bench builds two copies that share the same inputs. Both use `ADDR_W`=4, so the mailboxes sit at 0xE and 0xF, and neighbouring addresses such as 0xD are easy to reach. One copy has `IRQ_EN`=1 and is the copy under test. The other has `IRQ_EN`=0 and must keep both flags high through every scenario. The narrow address width lets the tests hit the mailbox decode boundaries and the set-versus-clear collision directly.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    typedef struct packed {
        logic en_n;
        logic wr_n;
        logic oe_n;
        logic busy_n;
    } side_ctl_t;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;

    function automatic int unsigned other_side(input int unsigned s);
        return (s == 0) ? 1 : 0;
    endfunction

    function automatic logic side_live(input side_ctl_t c);
        return !c.en_n && c.busy_n;
    endfunction

endpackage

// File: rtl/mbx_side_decode.sv
module mbx_side_decode
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter logic [ADDR_W-1:0] OWN_BOX = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  side_ctl_t         ctl,
    input  logic [ADDR_W-1:0] addr,
    output logic              clr_own,
    output logic              set_peer
);
    logic live;

    always_comb begin
        live     = side_live(ctl);
        set_peer = live && !ctl.wr_n && (addr == PEER_BOX);
        clr_own  = live && !ctl.oe_n && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell #(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_n
);
    generate
        if (ENABLE) begin : g_live
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst)          flag_q <= 1'b1;
                else if (set_req) flag_q <= 1'b0;
                else if (clr_req) flag_q <= 1'b1;
            end
            assign flag_n = flag_q;
        end else begin : g_off
            logic unused_req;
            assign unused_req = set_req ^ clr_req ^ clk ^ rst;
            assign flag_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/mbx_irq_ctl.sv
module mbx_irq_ctl
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter bit IRQ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en_n,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_busy_n,
    input  logic              b_en_n,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_busy_n,
    output logic              a_irq_n,
    output logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] BOX_B = '1;
    localparam logic [ADDR_W-1:0] BOX_A = BOX_B - 1'b1;

    side_ctl_t         ctl  [NUM_SIDES];
    logic [ADDR_W-1:0] addr [NUM_SIDES];
    logic [NUM_SIDES-1:0] clr_own, set_peer, irq_n;

    assign ctl[SIDE_A]  = '{en_n: a_en_n, wr_n: a_wr_n, oe_n: a_oe_n, busy_n: a_busy_n};
    assign ctl[SIDE_B]  = '{en_n: b_en_n, wr_n: b_wr_n, oe_n: b_oe_n, busy_n: b_busy_n};
    assign addr[SIDE_A] = a_addr;
    assign addr[SIDE_B] = b_addr;

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? BOX_A : BOX_B;
            localparam logic [ADDR_W-1:0] PEER = (s == 0) ? BOX_B : BOX_A;

            mbx_side_decode #(
                .ADDR_W  (ADDR_W),
                .OWN_BOX (OWN),
                .PEER_BOX(PEER)
            ) u_dec (
                .ctl     (ctl[s]),
                .addr    (addr[s]),
                .clr_own (clr_own[s]),
                .set_peer(set_peer[s])
            );

            mbx_flag_cell #(
                .ENABLE(IRQ_EN)
            ) u_flag (
                .clk    (clk),
                .rst    (rst),
                .set_req(set_peer[other_side(s)]),
                .clr_req(clr_own[s]),
                .flag_n (irq_n[s])
            );
        end
    endgenerate

    assign a_irq_n = irq_n[SIDE_A];
    assign b_irq_n = irq_n[SIDE_B];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 15,
    parameter bit IRQ_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              a_en_n,
    input logic              a_wr_n,
    input logic              a_oe_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_busy_n,
    input logic              b_en_n,
    input logic              b_wr_n,
    input logic              b_oe_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_busy_n,
    input logic              a_irq_n,
    input logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] TOP  = '1;
    localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

    logic set_a, clr_a, set_b, clr_b;
    assign set_a = !b_en_n && !b_wr_n && b_busy_n && (b_addr == NEXT);
    assign clr_a = !a_en_n && !a_oe_n && a_busy_n && (a_addr == NEXT);
    assign set_b = !a_en_n && !a_wr_n && a_busy_n && (a_addr == TOP);
    assign clr_b = !b_en_n && !b_oe_n && b_busy_n && (b_addr == TOP);

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (a_irq_n && b_irq_n));

    a_r2_r7_set_a: assert property (@(posedge clk) disable iff (rst)
        (IRQ_EN && set_a) |=> !a_irq_n);

    a_r3_set_b: assert property (@(posedge clk) disable iff (rst)
        (IRQ_EN && set_b) |=> !b_irq_n);

    a_r4_clear_a: assert property (@(posedge clk) disable iff (rst)
        (clr_a && !set_a) |=> a_irq_n);

    a_r5_clear_b: assert property (@(posedge clk) disable iff (rst)
        (clr_b && !set_b) |=> b_irq_n);

    a_r9_hold_a: assert property (@(posedge clk) disable iff (rst)
        (!set_a && !clr_a) |=> $stable(a_irq_n));

    a_r9_hold_b: assert property (@(posedge clk) disable iff (rst)
        (!set_b && !clr_b) |=> $stable(b_irq_n));

    a_r10_off_idle: assert property (@(posedge clk) disable iff (rst)
        !IRQ_EN |-> (a_irq_n && b_irq_n));
endmodule

bind mbx_irq_ctl mbx_irq_chk #(.ADDR_W(ADDR_W), .IRQ_EN(IRQ_EN)) u_chk (
    .clk(clk), .rst(rst),
    .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_busy_n(a_busy_n),
    .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_busy_n(b_busy_n),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
);

// File: tb/sim_mbx_irq_ctl.sv
module sim_mbx_irq_ctl;
    localparam int AW = 4;
    localparam logic [AW-1:0] BOX_A = 4'hE;
    localparam logic [AW-1:0] BOX_B = 4'hF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_en_n = 1, a_wr_n = 1, a_oe_n = 1, a_busy_n = 1;
    logic b_en_n = 1, b_wr_n = 1, b_oe_n = 1, b_busy_n = 1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n, off_a_irq_n, off_b_irq_n;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mbx_irq_ctl #(.ADDR_W(AW), .IRQ_EN(1'b1)) u0 (
        .clk(clk), .rst(rst),
        .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_busy_n(a_busy_n),
        .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_busy_n(b_busy_n),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n));

    mbx_irq_ctl #(.ADDR_W(AW), .IRQ_EN(1'b0)) u1 (
        .clk(clk), .rst(rst),
        .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_busy_n(a_busy_n),
        .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_busy_n(b_busy_n),
        .a_irq_n(off_a_irq_n), .b_irq_n(off_b_irq_n));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: inputs already set away from the edge, sample 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        {a_en_n, a_wr_n, a_oe_n, a_busy_n} = 4'b1111;
        {b_en_n, b_wr_n, b_oe_n, b_busy_n} = 4'b1111;
        a_addr = '0;
        b_addr = '0;
    endtask

    task automatic acc_a(input logic wr_n, input logic oe_n, input logic [AW-1:0] ad, input logic busy_n);
        a_en_n = 0; a_wr_n = wr_n; a_oe_n = oe_n; a_addr = ad; a_busy_n = busy_n;
    endtask

    task automatic acc_b(input logic wr_n, input logic oe_n, input logic [AW-1:0] ad, input logic busy_n);
        b_en_n = 0; b_wr_n = wr_n; b_oe_n = oe_n; b_addr = ad; b_busy_n = busy_n;
    endtask

    task automatic t_reset();
        rst = 1; idle();
        tick(); tick();
        check("R1 a during reset", a_irq_n, 1'b1);
        check("R1 b during reset", b_irq_n, 1'b1);
        rst = 0;
        tick();
        check("R1 a after reset", a_irq_n, 1'b1);
        check("R1 b after reset", b_irq_n, 1'b1);
    endtask

    task automatic t_set_clear_a();
        acc_b(0, 1, BOX_A, 1); tick(); idle();
        check("R2 a set by B write", a_irq_n, 1'b0);
        check("R2 b untouched", b_irq_n, 1'b1);
        check("R10 off copy a", off_a_irq_n, 1'b1);
        for (int i = 0; i < 3; i++) tick();
        check("R9 a held", a_irq_n, 1'b0);
        acc_b(1, 0, BOX_A, 1); tick(); idle();
        check("R8 peer read of A box", a_irq_n, 1'b0);
        acc_a(0, 0, BOX_A, 1); tick(); idle();
        check("R4 a cleared with wr low", a_irq_n, 1'b1);
        acc_b(0, 1, BOX_A, 1); tick(); idle();
        acc_a(1, 0, BOX_A, 1); tick(); idle();
        check("R4 a cleared by read", a_irq_n, 1'b1);
    endtask

    task automatic t_set_clear_b();
        acc_a(0, 1, BOX_B, 1); tick(); idle();
        check("R3 b set by A write", b_irq_n, 1'b0);
        check("R3 a untouched", a_irq_n, 1'b1);
        check("R10 off copy b", off_b_irq_n, 1'b1);
        tick(); tick();
        check("R9 b held", b_irq_n, 1'b0);
        acc_b(1, 0, BOX_B, 1); tick(); idle();
        check("R5 b cleared by read", b_irq_n, 1'b1);
    endtask

    task automatic t_busy();
        acc_b(0, 1, BOX_A, 0); tick(); idle();
        check("R6 busy blocks set a", a_irq_n, 1'b1);
        acc_a(0, 1, BOX_B, 0); tick(); idle();
        check("R6 busy blocks set b", b_irq_n, 1'b1);
        acc_b(0, 1, BOX_A, 1); tick(); idle();
        acc_a(1, 0, BOX_A, 0); tick(); idle();
        check("R6 busy blocks clear a", a_irq_n, 1'b0);
        acc_a(1, 0, BOX_A, 1); tick(); idle();
        check("R6 clear after busy lifts", a_irq_n, 1'b1);
    endtask

    task automatic t_collide();
        acc_b(0, 1, BOX_A, 1); acc_a(1, 0, BOX_A, 1); tick(); idle();
        check("R7 set wins from high", a_irq_n, 1'b0);
        acc_b(0, 1, BOX_A, 1); acc_a(1, 0, BOX_A, 1); tick(); idle();
        check("R7 set wins from low", a_irq_n, 1'b0);
        acc_a(1, 0, BOX_A, 1); tick(); idle();
        check("R7 later clear", a_irq_n, 1'b1);
        acc_a(0, 1, BOX_B, 1); acc_b(1, 0, BOX_B, 1); tick(); idle();
        check("R7 set wins for b", b_irq_n, 1'b0);
        acc_b(1, 0, BOX_B, 1); tick(); idle();
    endtask

    task automatic t_ignored();
        acc_b(0, 1, 4'hD, 1); tick(); idle();
        check("R8 B write to 0xD", a_irq_n, 1'b1);
        acc_a(0, 1, 4'hD, 1); tick(); idle();
        check("R8 A write to 0xD", b_irq_n, 1'b1);
        acc_a(0, 1, BOX_A, 1); tick(); idle();
        check("R8 A write own box", a_irq_n, 1'b1);
        acc_b(0, 1, BOX_B, 1); tick(); idle();
        check("R8 B write own box", b_irq_n, 1'b1);
        b_en_n = 1; b_wr_n = 0; b_addr = BOX_A; tick(); idle();
        check("R8 B disabled write", a_irq_n, 1'b1);
        acc_a(0, 1, BOX_B, 1); tick(); idle();
        acc_a(1, 0, BOX_B, 1); tick(); idle();
        check("R8 peer read of B box", b_irq_n, 1'b0);
        a_en_n = 1; a_oe_n = 0; a_addr = BOX_A; b_en_n = 1; b_oe_n = 0; b_addr = BOX_B; tick(); idle();
        check("R8 disabled read of B box", b_irq_n, 1'b0);
        check("R10 off copy still idle", off_b_irq_n, 1'b1);
        acc_b(1, 0, BOX_B, 1); tick(); idle();
        check("R5 final clear", b_irq_n, 1'b1);
    endtask

    initial begin
        #1;
        t_reset();
        t_set_clear_a();
        t_set_clear_b();
        t_busy();
        t_collide();
        t_ignored();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule